// File: doc/BRIEF.md
# Radix-2 Add-Compare-Select Trellis Step Unit

This block advances the path metrics of a 16-state (constraint length 5) convolutional decoder by one trellis step. It holds the 16 accumulated path metrics internally. For each step it splits them into even and odd states and feeds them, with one branch metric per butterfly, to eight parallel radix-2 butterflies. Each butterfly forms four candidate sums with signed 16-bit saturating arithmetic and keeps the larger candidate for each of its two new states. The metric is maximised.

A step starts when `in_valid` is high while `in_ready` is high. The butterfly results are registered in the first cycle. In the second cycle they are optionally normalised by subtracting their minimum, then written back over the stored metrics. At that point `out_valid` pulses and the decision word is presented. Branch metric generation and traceback sit outside the block.

Top module: `acs_trellis_step`

## Requirements
- R1: After reset the stored metric of state 0 is 0 and every other state holds -16384; `out_valid` is 0, `dec_word` is 0 and `in_ready` is 1.
- R2: Butterfly i (0..7) reads P0 = state 2i, P1 = state 2i+1 and branch metric B[i] from `bm_vec[16i+15:16i]`. New state i takes the larger of sat(P0+B[i]) and sat(P1-B[i]).
- R3: New state i+8 takes the larger of sat(P0-B[i]) and sat(P1+B[i]).
- R4: Every sum and difference is clamped to the range -32768..+32767.
- R5: Bit s of `dec_word` is 1 when the first candidate of new state s is greater than or equal to the second. A tie gives 1.
- R6: A step is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for the following cycle. `out_valid` is 1 for exactly the one cycle that begins two edges after acceptance, and the new metrics and decisions appear on `metric_vec` and `dec_word` in that same cycle.
- R7: When `norm_req` is 1 at acceptance, the minimum of the 16 new metrics is subtracted from each of them with saturation before write-back. The stored minimum is then 0.
- R8: When `norm_req` is 0 at acceptance, the new metrics are stored unchanged. State s is reported on `metric_vec[16s+15:16s]`.
- R9: `in_valid` asserted while `in_ready` is 0 starts no step. Outside a write-back, `metric_vec` and `dec_word` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Branch metrics present, step requested |
| in_ready | output | 1 | Block can accept a step |
| norm_req | input | 1 | Normalise the results of this step |
| bm_vec | input | 128 | Eight signed 16-bit branch metrics, butterfly i in lane i |
| out_valid | output | 1 | One-cycle pulse at write-back |
| dec_word | output | 16 | Survivor decisions, bit s for new state s |
| metric_vec | output | 256 | Stored signed 16-bit path metrics, state s in lane s |

## Verification
The bench targets candidate ties, positive saturation of a metric already at the ceiling, and inputs offered while the block is busy.

A design that broke ties toward the second candidate would show zero decision bits after the all-zero step from reset. A wrapping adder would turn a 32767 metric negative. A block that took the busy-cycle request would run a second, unwanted step. The vector table mixes normalised and raw steps with extreme branch metrics. A swapped even/odd split, a mislabelled output half or a missing normalisation would therefore show up as a lane mismatch against the bench's own trellis model.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int ACS_MW = 16;
  typedef logic signed [ACS_MW-1:0] metric_t;
  localparam metric_t METRIC_MAX = metric_t'({1'b0, {(ACS_MW-1){1'b1}}});
  localparam metric_t METRIC_MIN = metric_t'({1'b1, {(ACS_MW-1){1'b0}}});
  localparam metric_t METRIC_INIT_NEG = metric_t'(-(2 ** (ACS_MW - 2)));

  function automatic metric_t clamp_ext(input logic signed [ACS_MW:0] s);
    if (s[ACS_MW] != s[ACS_MW-1]) return s[ACS_MW] ? METRIC_MIN : METRIC_MAX;
    return metric_t'(s[ACS_MW-1:0]);
  endfunction

  function automatic metric_t sat_add(input metric_t a, input metric_t b);
    logic signed [ACS_MW:0] s;
    s = {a[ACS_MW-1], a} + {b[ACS_MW-1], b};
    return clamp_ext(s);
  endfunction

  function automatic metric_t sat_sub(input metric_t a, input metric_t b);
    logic signed [ACS_MW:0] s;
    s = {a[ACS_MW-1], a} - {b[ACS_MW-1], b};
    return clamp_ext(s);
  endfunction
endpackage

// File: rtl/acs_bfly.sv
module acs_bfly
  import acs_pkg::*;
(
  input  metric_t p_even,
  input  metric_t p_odd,
  input  metric_t bm,
  output metric_t m_upper,
  output metric_t m_lower,
  output logic    d_upper,
  output logic    d_lower
);
  metric_t c_ue, c_uo, c_le, c_lo;

  always_comb begin
    c_ue = sat_add(p_even, bm);
    c_uo = sat_sub(p_odd, bm);
    c_le = sat_sub(p_even, bm);
    c_lo = sat_add(p_odd, bm);
    d_upper = (c_ue >= c_uo);
    d_lower = (c_le >= c_lo);
    m_upper = d_upper ? c_ue : c_uo;
    m_lower = d_lower ? c_le : c_lo;
  end
endmodule

// File: rtl/acs_norm.sv
module acs_norm
  import acs_pkg::*;
#(
  parameter int N_ST = 16
) (
  input  logic    en,
  input  metric_t vin  [N_ST],
  output metric_t vout [N_ST]
);
  metric_t vmin;

  always_comb begin
    vmin = vin[0];
    for (int s = 1; s < N_ST; s++) begin
      if (vin[s] < vmin) vmin = vin[s];
    end
    for (int s = 0; s < N_ST; s++) begin
      vout[s] = en ? sat_sub(vin[s], vmin) : vin[s];
    end
  end
endmodule

// File: rtl/acs_trellis_step.sv
module acs_trellis_step
  import acs_pkg::*;
#(
  parameter int N_BFLY = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       norm_req,
  input  logic [N_BFLY*ACS_MW-1:0]   bm_vec,
  output logic                       out_valid,
  output logic [2*N_BFLY-1:0]        dec_word,
  output logic [2*N_BFLY*ACS_MW-1:0] metric_vec
);
  localparam int N_ST = 2 * N_BFLY;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  metric_t            store_q [N_ST];
  metric_t            store_d [N_ST];
  metric_t            stage_q [N_ST];
  metric_t            stage_d [N_ST];
  metric_t            bfly_m  [N_ST];
  metric_t            norm_m  [N_ST];
  logic [N_ST-1:0]    bfly_dec;
  logic [N_ST-1:0]    stage_dec_q, stage_dec_d;
  logic [N_ST-1:0]    dec_q, dec_d;
  logic               norm_q, norm_d;
  logic               busy_q, busy_d;
  logic               ov_q, ov_d;
  logic               accept;

  assign in_ready = ~busy_q;
  assign accept   = in_valid & ~busy_q;

  generate
    for (genvar i = 0; i < N_BFLY; i++) begin : g_bfly
      acs_bfly u_bfly (
        .p_even  (store_q[2*i]),
        .p_odd   (store_q[2*i+1]),
        .bm      (metric_t'(bm_vec[i*ACS_MW +: ACS_MW])),
        .m_upper (bfly_m[i]),
        .m_lower (bfly_m[i+N_BFLY]),
        .d_upper (bfly_dec[i]),
        .d_lower (bfly_dec[i+N_BFLY])
      );
    end
  endgenerate

  acs_norm #(.N_ST(N_ST)) u_norm (
    .en   (norm_q),
    .vin  (stage_q),
    .vout (norm_m)
  );

  // next-state logic
  always_comb begin
    busy_d      = accept;
    ov_d        = busy_q;
    norm_d      = accept ? norm_req : norm_q;
    stage_dec_d = accept ? bfly_dec : stage_dec_q;
    dec_d       = busy_q ? stage_dec_q : dec_q;
    for (int s = 0; s < N_ST; s++) begin
      stage_d[s] = accept ? bfly_m[s] : stage_q[s];
      store_d[s] = busy_q ? norm_m[s] : store_q[s];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q      <= 1'b0;
      ov_q        <= 1'b0;
      norm_q      <= 1'b0;
      stage_dec_q <= '0;
      dec_q       <= '0;
      for (int s = 0; s < N_ST; s++) begin
        stage_q[s] <= '0;
        store_q[s] <= (s == 0) ? metric_t'(0) : METRIC_INIT_NEG;
      end
    end else begin
      busy_q      <= busy_d;
      ov_q        <= ov_d;
      norm_q      <= norm_d;
      stage_dec_q <= stage_dec_d;
      dec_q       <= dec_d;
      for (int s = 0; s < N_ST; s++) begin
        stage_q[s] <= stage_d[s];
        store_q[s] <= store_d[s];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < N_ST; s++) metric_vec[s*ACS_MW +: ACS_MW] = store_q[s];
  end
  assign dec_word  = dec_q;
  assign out_valid = ov_q;

  // checker helpers
  logic has_zero, has_neg;
  always_comb begin
    has_zero = 1'b0;
    has_neg  = 1'b0;
    for (int s = 0; s < N_ST; s++) begin
      if (store_q[s] == 0) has_zero = 1'b1;
      if (store_q[s] < 0)  has_neg  = 1'b1;
    end
  end

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |=> !in_ready);
  // R6
  valid_two_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |-> ##2 out_valid);
  // R6
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |=> !out_valid);
  // R9
  hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !out_valid |-> ($stable(metric_vec) && $stable(dec_word)));
  // R7
  norm_min_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && norm_q) |-> (has_zero && !has_neg));
endmodule

// File: tb/acs_trellis_step_test.sv
module acs_trellis_step_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         norm_req = 1'b0;
  logic [127:0] bm_vec = '0;
  logic         out_valid;
  logic [15:0]  dec_word;
  logic [255:0] metric_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int      mdl_m [16];
  logic [15:0] mdl_d;

  always #5 clk = ~clk;

  acs_trellis_step uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .norm_req(norm_req), .bm_vec(bm_vec), .out_valid(out_valid),
    .dec_word(dec_word), .metric_vec(metric_vec)
  );

  localparam int NV = 6;
  localparam logic [127:0] VBM [NV] = '{
    128'h0064_FF9C_0032_FFCE_000A_FFF6_0000_0001,
    128'h00C8_0064_FF38_FF9C_0001_0002_0003_0004,
    128'h7FFF_8000_7FFF_8000_1000_F000_0800_F800,
    128'h0000_0000_0000_0000_0000_0000_0000_0000,
    128'h1234_EDCC_4000_C000_0FFF_F001_00FF_FF01,
    128'h8000_8000_8000_8000_7FFF_7FFF_7FFF_7FFF
  };
  localparam logic VNORM [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  function automatic int sat16(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int lane(input int s);
    return int'($signed(metric_vec[16*s +: 16]));
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 16; s++) mdl_m[s] = (s == 0) ? 0 : -16384;
    mdl_d = '0;
  endtask

  task automatic model_step(input logic [127:0] bm, input logic nrm);
    int n [16];
    int mn;
    for (int i = 0; i < 8; i++) begin
      int b, c0, c1, c2, c3;
      b  = int'($signed(bm[16*i +: 16]));
      c0 = sat16(mdl_m[2*i] + b);   c1 = sat16(mdl_m[2*i+1] - b);
      c2 = sat16(mdl_m[2*i] - b);   c3 = sat16(mdl_m[2*i+1] + b);
      mdl_d[i]   = (c0 >= c1); n[i]   = (c0 >= c1) ? c0 : c1;
      mdl_d[i+8] = (c2 >= c3); n[i+8] = (c2 >= c3) ? c2 : c3;
    end
    mn = n[0];
    for (int s = 1; s < 16; s++) if (n[s] < mn) mn = n[s];
    for (int s = 0; s < 16; s++) mdl_m[s] = nrm ? sat16(n[s] - mn) : n[s];
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    int bad_s;
    bad_s = -1;
    for (int s = 15; s >= 0; s--) if (lane(s) != mdl_m[s]) bad_s = s;
    if (bad_s < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " metric lane"}, lane(bad_s), mdl_m[bad_s]);
    check(dec_word == mdl_d, {req, " decisions"}, int'(dec_word), int'(mdl_d));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  // R6 handshake observed on every step
  task automatic run_step(input logic [127:0] bm, input logic nrm);
    in_valid = 1'b1; bm_vec = bm; norm_req = nrm;
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready && !out_valid, "R6 busy cycle", int'({in_ready, out_valid}), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 out_valid pulse", int'(out_valid), 1);
    model_step(bm, nrm);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(!out_valid && in_ready && dec_word == 16'h0, "R1 control",
          int'({out_valid, in_ready}), 1);
    check_model("R1");

    // R5 ties after reset with zero branch metrics
    run_step('0, 1'b0);
    check(dec_word == 16'hFFFF, "R5 tie decisions", int'(dec_word), 16'hFFFF);
    check(lane(0) == 0 && lane(8) == 0 && lane(1) == -16384, "R5 tie metrics",
          lane(1), -16384);

    // R4 positive saturation, R2/R3 lane placement
    do_reset();
    run_step(128'h7FFF, 1'b0);
    check(lane(0) == 32767, "R2 state0", lane(0), 32767);
    check(lane(8) == 16383, "R3 state8", lane(8), 16383);
    check(dec_word[0] == 1'b1 && dec_word[8] == 1'b0, "R5 decisions", int'(dec_word), 1);
    run_step(128'h7FFF, 1'b0);
    check(lane(0) == 32767, "R4 clamp high", lane(0), 32767);
    check_model("R4");

    // table of vectors against the trellis model: R2 R3 R7 R8
    do_reset();
    for (int v = 0; v < NV; v++) begin
      run_step(VBM[v], VNORM[v]);
      check_model(VNORM[v] ? "R7 vector" : "R8 vector");
      if (VNORM[v]) begin
        int mn;
        mn = lane(0);
        for (int s = 1; s < 16; s++) if (lane(s) < mn) mn = lane(s);
        check(mn == 0, "R7 min zero", mn, 0);
      end
    end

    // R9 request during busy cycle is ignored
    in_valid = 1'b1; bm_vec = VBM[0]; norm_req = 1'b0;
    @(negedge clk);
    bm_vec = VBM[5]; norm_req = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model_step(VBM[0], 1'b0);
    check(out_valid == 1'b1, "R9 first pulse", int'(out_valid), 1);
    check_model("R9 single step");
    @(negedge clk);
    check(out_valid == 1'b0, "R9 no second step", int'(out_valid), 0);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R9 still idle", int'(out_valid), 0);
    check_model("R9 hold");

    done = 1;
    summary();
    $finish;
  end
endmodule